// File: doc/BRIEF.md
# Two-Level Overcurrent Breaker Timer

This block decides when the gate drive of a hot-swap load switch must be shut off. Two comparator flags come in from the current-sense resistor. The slow flag reports a drop above the fixed low level. The fast flag reports a drop above the selectable quick-trip level.

The fast path acts on the next clock edge, or it is ignored when the quick-trip setting is off. The slow path behaves as a filter. It trips only when the slow flag stays high, without a break, for the whole programmed breaker delay. A spike shorter than that delay leaves the gate on.

After either path trips, the trip is held. The gate stays off until reset.

A three-state machine does the work:
- ARMED: idle, counter at zero.
- TIMING: the slow flag is being timed.
- TRIPPED: absorbing.

The transitions are:
- ARMED→TIMING: first slow sample while the delay is still short of expiry.
- TIMING→TIMING: slow flag still high and the count below the limit.
- TIMING→ARMED: slow flag dropped, so the counter clears.
- ARMED/TIMING→TRIPPED: either an enabled fast flag, or the slow count reaching the limit.
- TRIPPED→ARMED: only through reset.

The delay counts are computed from a clock-frequency parameter.

Top module: `cb_breaker_timer`

## Requirements
- R1: After reset, gate_en_o is 1 and trip_o is 0.
- R2: dly_sel_i selects the breaker delay as 00 = 5 µs, 01 = 50 µs, 10 = 150 µs, 11 = 400 µs. The delay is expressed as CLK_HZ × t clock cycles (250, 2500, 7500 and 20000 at 50 MHz).
- R3: With the slow flag sampled high on N consecutive rising edges, the block trips at the Nth edge when N equals the selected delay count.
- R4: A slow-flag run shorter than the delay count, followed by a low sample, causes no trip. The count restarts from zero on the next high run.
- R5: With qt_sel_i at 01, 10 or 11 (quick-trip enabled), a fast flag sampled high at one edge makes gate_en_o 0 after that edge, with no filtering.
- R6: With qt_sel_i = 00 (quick-trip off), the fast flag has no effect.
- R7: A trip is latched. gate_en_o stays 0 and trip_o stays 1, whatever the flags do, until reset. gate_en_o is always the inverse of trip_o.
- R8: The controller uses only the states ARMED, TIMING and TRIPPED, and the counter is zero whenever the state is not TIMING.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_flag_i | input | 1 | Sense drop above the low (filtered) level |
| fast_flag_i | input | 1 | Sense drop above the quick-trip level |
| dly_sel_i | input | 2 | Breaker delay code |
| qt_sel_i | input | 2 | Quick-trip code, 00 = off |
| gate_en_o | output | 1 | Gate drive enable, 1 = on |
| trip_o | output | 1 | Latched trip indication |

## Verification
The bench holds the slow flag for exactly the delay count and for one cycle less, at every delay code. An off-by-one in the limit compare would trip early or trip late. A run is also broken by a single low cycle and then resumed. A counter that fails to clear would add the two runs together and trip falsely. The fast flag is pulsed under each quick-trip code. An off code that still acted, or an on code that filtered, would be visible on gate_en_o one edge later. After a trip, both flags are released to show that the trip does not self-clear.

// File: rtl/cb_pkg.sv
package cb_pkg;

    typedef enum logic [1:0] {
        CB_ARMED   = 2'd0,
        CB_TIMING  = 2'd1,
        CB_TRIPPED = 2'd2
    } cb_state_e;

    localparam logic [1:0] QT_OFF = 2'b00;

    // microseconds to clock cycles
    function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                     longint unsigned us);
        return (clk_hz * us) / 64'd1_000_000;
    endfunction

    function automatic longint unsigned max4(longint unsigned a, longint unsigned b,
                                             longint unsigned c, longint unsigned d);
        longint unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/cb_delay_lut.sv
module cb_delay_lut
    import cb_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 50_000_000,
    parameter longint unsigned DLY0_US = 5,
    parameter longint unsigned DLY1_US = 50,
    parameter longint unsigned DLY2_US = 150,
    parameter longint unsigned DLY3_US = 400,
    parameter int unsigned CW = 15
) (
    input  logic [1:0]    sel_i,
    output logic [CW-1:0] limit_o
);

    logic [CW-1:0] tbl [4];

    for (genvar i = 0; i < 4; i++) begin : g_tbl
        localparam longint unsigned T_US = (i == 0) ? DLY0_US :
                                           (i == 1) ? DLY1_US :
                                           (i == 2) ? DLY2_US : DLY3_US;
        localparam longint unsigned CYC = us_to_cycles(CLK_HZ, T_US);
        assign tbl[i] = CW'(CYC);
    end

    assign limit_o = tbl[sel_i];

endmodule

// File: rtl/cb_qt_enable.sv
module cb_qt_enable
    import cb_pkg::*;
(
    input  logic [1:0] qt_sel_i,
    input  logic       fast_flag_i,
    output logic       fast_trip_o
);

    assign fast_trip_o = fast_flag_i && (qt_sel_i != QT_OFF);

endmodule

// File: rtl/cb_breaker_timer.sv
module cb_breaker_timer
    import cb_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 50_000_000,
    parameter longint unsigned DLY0_US = 5,
    parameter longint unsigned DLY1_US = 50,
    parameter longint unsigned DLY2_US = 150,
    parameter longint unsigned DLY3_US = 400
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       slow_flag_i,
    input  logic       fast_flag_i,
    input  logic [1:0] dly_sel_i,
    input  logic [1:0] qt_sel_i,
    output logic       gate_en_o,
    output logic       trip_o
);

    localparam longint unsigned MAX_CYC =
        us_to_cycles(CLK_HZ, max4(DLY0_US, DLY1_US, DLY2_US, DLY3_US));
    localparam int unsigned CW = $clog2(MAX_CYC + 1);

    cb_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] dly_limit;
    logic          fast_trip;
    logic          slow_done;

    cb_delay_lut #(
        .CLK_HZ (CLK_HZ),
        .DLY0_US(DLY0_US),
        .DLY1_US(DLY1_US),
        .DLY2_US(DLY2_US),
        .DLY3_US(DLY3_US),
        .CW     (CW)
    ) u_lut (
        .sel_i  (dly_sel_i),
        .limit_o(dly_limit)
    );

    cb_qt_enable u_qt (
        .qt_sel_i   (qt_sel_i),
        .fast_flag_i(fast_flag_i),
        .fast_trip_o(fast_trip)
    );

    // this sample completes the run when count+1 reaches the limit
    assign slow_done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, dly_limit};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CB_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CB_ARMED, CB_TIMING: begin
                if (fast_trip) begin
                    state_d = CB_TRIPPED;
                    cnt_d   = '0;
                end else if (slow_flag_i) begin
                    if (slow_done) begin
                        state_d = CB_TRIPPED;
                        cnt_d   = '0;
                    end else begin
                        state_d = CB_TIMING;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end else begin
                    state_d = CB_ARMED;
                    cnt_d   = '0;
                end
            end
            CB_TRIPPED: begin
                state_d = CB_TRIPPED;
                cnt_d   = '0;
            end
            default: begin
                state_d = CB_TRIPPED;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        gate_en_o = (state_q != CB_TRIPPED);
        trip_o    = (state_q == CB_TRIPPED);
    end

endmodule

// File: rtl/cb_breaker_checker.sv
module cb_breaker_checker
    import cb_pkg::*;
#(
    parameter int unsigned CW = 15
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          slow_flag_i,
    input logic          fast_flag_i,
    input logic [1:0]    qt_sel_i,
    input cb_state_e     state_q,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] dly_limit,
    input logic          gate_en_o,
    input logic          trip_o
);

    p_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip_o |=> (trip_o && !gate_en_o));

    p_gate_inverse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_en_o != trip_o);

    p_fast_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast_flag_i && qt_sel_i != 2'b00) |=> !gate_en_o);

    p_fast_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trip_o && !slow_flag_i && qt_sel_i == 2'b00) |=> !trip_o);

    p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trip_o && !slow_flag_i) |=> (cnt_q == '0));

    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CB_TIMING) |-> (cnt_q < dly_limit));

    p_legal_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CB_ARMED || state_q == CB_TIMING || state_q == CB_TRIPPED));

    p_cnt_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != CB_TIMING) |-> (cnt_q == '0));

endmodule

bind cb_breaker_timer cb_breaker_checker #(.CW(CW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slow_flag_i(slow_flag_i),
    .fast_flag_i(fast_flag_i),
    .qt_sel_i   (qt_sel_i),
    .state_q    (state_q),
    .cnt_q      (cnt_q),
    .dly_limit  (dly_limit),
    .gate_en_o  (gate_en_o),
    .trip_o     (trip_o)
);

// File: tb/cb_breaker_timer_test.sv
module cb_breaker_timer_test;

    localparam longint unsigned CLK_HZ = 50_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow = 1'b0;
    logic       fast = 1'b0;
    logic [1:0] dly = 2'b00;
    logic [1:0] qt = 2'b00;
    logic       gate_en;
    logic       trip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cb_breaker_timer #(.CLK_HZ(CLK_HZ)) uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .slow_flag_i(slow),
        .fast_flag_i(fast),
        .dly_sel_i  (dly),
        .qt_sel_i   (qt),
        .gate_en_o  (gate_en),
        .trip_o     (trip)
    );

    // vector: {dly[1:0], qt[1:0], fast, slow_len[15:0]}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {2'b00, 2'b00, 1'b0, 16'd249},
        {2'b00, 2'b00, 1'b0, 16'd250},
        {2'b01, 2'b00, 1'b0, 16'd2499},
        {2'b01, 2'b00, 1'b0, 16'd2500},
        {2'b10, 2'b00, 1'b0, 16'd7499},
        {2'b10, 2'b00, 1'b0, 16'd7500},
        {2'b11, 2'b00, 1'b0, 16'd19999},
        {2'b11, 2'b00, 1'b0, 16'd20000},
        {2'b00, 2'b00, 1'b1, 16'd0},
        {2'b11, 2'b01, 1'b1, 16'd0},
        {2'b11, 2'b10, 1'b1, 16'd0},
        {2'b11, 2'b11, 1'b1, 16'd0},
        {2'b00, 2'b00, 1'b1, 16'd100},
        {2'b01, 2'b11, 1'b0, 16'd100}
    };

    function automatic int delay_cycles(logic [1:0] code);
        int us;
        case (code)
            2'b00: us = 5;
            2'b01: us = 50;
            2'b10: us = 150;
            default: us = 400;
        endcase
        return int'((CLK_HZ * longint'(us)) / 1_000_000);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        slow = 1'b0;
        fast = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic hold_slow(int n);
        slow = 1'b1;
        repeat (n) @(negedge clk);
        slow = 1'b0;
    endtask

    initial begin
        do_reset();
        chk("R1 gate_en after reset", gate_en, 1'b1);
        chk("R1 trip after reset", trip, 1'b0);

        // table walk: R2/R3/R4 slow path, R5/R6 fast path
        for (int v = 0; v < NV; v++) begin
            logic [1:0] vd;
            logic [1:0] vq;
            logic vf;
            int len;
            logic exp;
            vd = VEC[v][20:19];
            vq = VEC[v][18:17];
            vf = VEC[v][16];
            len = int'(VEC[v][15:0]);
            do_reset();
            dly = vd;
            qt = vq;
            if (vf) begin
                fast = 1'b1;
                @(negedge clk);
                fast = 1'b0;
            end
            if (len > 0) hold_slow(len);
            repeat (2) @(negedge clk);
            exp = (vf && vq != 2'b00) || (len >= delay_cycles(vd));
            chk($sformatf("R2/R3 vector %0d trip", v), trip, exp);
            chk($sformatf("R7 vector %0d gate", v), gate_en, !exp);
        end

        // R3 exact edge: at 5 us, still on after 249 samples, off after 250
        do_reset();
        dly = 2'b00;
        qt = 2'b00;
        slow = 1'b1;
        repeat (249) @(negedge clk);
        chk("R3 gate before limit", gate_en, 1'b1);
        @(negedge clk);
        chk("R3 gate at limit", gate_en, 1'b0);
        slow = 1'b0;

        // R4 broken run does not accumulate
        do_reset();
        hold_slow(200);
        @(negedge clk);
        hold_slow(200);
        repeat (3) @(negedge clk);
        chk("R4 broken runs no trip", trip, 1'b0);

        // R5 timing: fast seen at one edge, gate off right after it
        do_reset();
        qt = 2'b10;
        fast = 1'b1;
        @(negedge clk);
        fast = 1'b0;
        chk("R5 fast trip next edge", gate_en, 1'b0);

        // R6 fast held long with quick-trip off
        do_reset();
        qt = 2'b00;
        fast = 1'b1;
        repeat (50) @(negedge clk);
        fast = 1'b0;
        chk("R6 fast ignored when off", gate_en, 1'b1);

        // R7 latch survives released flags and changed codes
        do_reset();
        qt = 2'b01;
        fast = 1'b1;
        @(negedge clk);
        fast = 1'b0;
        qt = 2'b00;
        repeat (100) @(negedge clk);
        chk("R7 trip held", trip, 1'b1);
        chk("R7 gate held off", gate_en, 1'b0);
        do_reset();
        chk("R1 reset clears trip", trip, 1'b0);

        // R8 after a trip and a reset, the slow path still times from zero
        dly = 2'b00;
        hold_slow(249);
        repeat (2) @(negedge clk);
        chk("R8 counter restarts after reset", trip, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule